// File: doc/BRIEF.md
# Debug Module-Select Receiver

This block sits behind a JTAG TAP and is used while the debug instruction is loaded. It watches the TAP strobes on the TCK clock and decodes one serial frame per pass through the data-register path. Each frame carries a one-bit select marker, a module identifier and a 32-bit check value. The block verifies the check value and, when the update strobe arrives, latches which debug module is in use.

After it has received the frame, the block answers on TDO in the same shift pass. The answer is a 4-bit status word followed by a 32-bit check value computed over that status. A frame whose marker is 0 is a command meant for the module already selected. This block lets such a frame pass with no effect and keeps TDO low. The identifier 0 selects the system-bus debug module and 1 selects the CPU debug module. No other identifier is valid.

Top module: `dbg_modsel_rx`

## Requirements
- R1: A frame restarts at the capture strobe. Shift cycle 0 carries the marker bit, cycles 1..ID_W carry the identifier MSB first, and the next 32 cycles carry the check value MSB first. The check value is computed over marker and identifier with polynomial 0x04C11DB7, fed one bit per cycle MSB-side, seeded with all ones and not inverted at the end.
- R2: In shift cycles ID_W+33 to ID_W+36 of a marker-1 frame, TDO presents the status word MSB first. Bit 3 is 1 exactly when the received check value differs from the computed one.
- R3: Status bit 1 is 1 exactly when the identifier is 2 or above. Status bits 2 and 0 are always 0.
- R4: In the 32 shift cycles after the status, TDO presents MSB first a check value over the 4 status bits. It starts from all ones, uses the same polynomial and is not inverted. Its last bit is in shift cycle ID_W+68.
- R5: On the update strobe after a complete marker-1 frame, mod_id takes the identifier and mod_valid goes to 1. This happens only if the check value matched and the identifier is 0 or 1. Otherwise both outputs keep their values.
- R6: A frame whose marker is 0 changes neither mod_id nor mod_valid, and TDO stays 0 throughout it.
- R7: tap_reset clears mod_id to 0 and mod_valid to 0.
- R8: TDO is 0 whenever shift_dr is low or debug_sel is low. While debug_sel is low, all strobes are ignored.
- R9: An update strobe that comes before all 32 received check bits have been shifted in leaves the selection unchanged.
- R10: Frames back to back each restart both check-value accumulators at capture, so one frame's result does not depend on the frame before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_reset | input | 1 | Test-logic reset, active high, asynchronous |
| debug_sel | input | 1 | Debug instruction active |
| capture_dr | input | 1 | TAP in capture-DR |
| shift_dr | input | 1 | TAP in shift-DR |
| update_dr | input | 1 | TAP in update-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| mod_id | output | ID_W | Latched module identifier |
| mod_valid | output | 1 | A module has been selected |

## Verification
The properties assume that the TAP asserts at most one of capture_dr, shift_dr and update_dr in any cycle. They also assume that update comes only after shift has ended, as a real TAP controller sequences it. The bench drives every frame as capture, a run of shift cycles and one update cycle, so it never overlaps strobes. It draws marker, identifier, checksum corruption and truncation at random, and adds directed cases for reset, a deselected instruction and a short frame.

// File: rtl/dbg_modsel_rx.sv
module dbg_modsel_rx #(
  parameter int ID_W    = 4,
  parameter int NUM_MOD = 2,
  parameter int CRC_W   = 32,
  parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7
) (
  input  logic            tck,
  input  logic            tap_reset,
  input  logic            debug_sel,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            tdi,
  output logic            tdo,
  output logic [ID_W-1:0] mod_id,
  output logic            mod_valid
);
  localparam int STAT_W = 4;
  localparam int RX_END = 1 + ID_W + CRC_W;
  localparam int OC_BEG = RX_END + STAT_W;
  localparam int LAST   = OC_BEG + CRC_W;
  localparam int CW     = $clog2(LAST + 1);

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    return {c[CRC_W-2:0], 1'b0} ^ ((c[CRC_W-1] ^ b) ? POLY : '0);
  endfunction

  logic [CW-1:0]    bit_cnt;
  logic             marker;
  logic [ID_W-1:0]  id_sr;
  logic [CRC_W-1:0] rx_crc, calc_crc, out_crc;

  wire crc_bad  = rx_crc != calc_crc;
  wire id_bad   = 32'(id_sr) >= 32'(NUM_MOD);
  wire [STAT_W-1:0] stat = {crc_bad, 1'b0, id_bad, 1'b0};
  wire [1:0] sidx = 2'(bit_cnt - CW'(RX_END));
  wire stat_bit = stat[~sidx];

  wire in_id    = bit_cnt != '0 && bit_cnt <= CW'(ID_W);
  wire in_rx    = bit_cnt > CW'(ID_W) && bit_cnt < CW'(RX_END);
  wire in_stat  = bit_cnt >= CW'(RX_END) && bit_cnt < CW'(OC_BEG);
  wire in_ocrc  = bit_cnt >= CW'(OC_BEG) && bit_cnt < CW'(LAST);
  wire complete = bit_cnt >= CW'(RX_END);
  wire sel_ok   = marker && complete && !crc_bad && !id_bad;

  assign tdo = debug_sel && shift_dr && marker &&
               ((in_stat && stat_bit) || (in_ocrc && out_crc[CRC_W-1]));

  always_ff @(posedge tck or posedge tap_reset) begin
    if (tap_reset) begin
      bit_cnt   <= '0;
      marker    <= 1'b0;
      id_sr     <= '0;
      rx_crc    <= '0;
      calc_crc  <= '1;
      out_crc   <= '1;
      mod_id    <= '0;
      mod_valid <= 1'b0;
    end else if (debug_sel) begin
      if (capture_dr) begin
        bit_cnt  <= '0;
        marker   <= 1'b0;
        id_sr    <= '0;
        rx_crc   <= '0;
        calc_crc <= '1;
        out_crc  <= '1;
      end else if (shift_dr) begin
        if (bit_cnt != CW'(LAST)) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == '0) begin
          marker   <= tdi;
          calc_crc <= crc_step(calc_crc, tdi);
        end else if (in_id) begin
          id_sr    <= ID_W'({id_sr, tdi});
          calc_crc <= crc_step(calc_crc, tdi);
        end else if (in_rx) begin
          rx_crc   <= {rx_crc[CRC_W-2:0], tdi};
        end else if (in_stat) begin
          out_crc  <= crc_step(out_crc, stat_bit);
        end else if (in_ocrc) begin
          out_crc  <= {out_crc[CRC_W-2:0], 1'b0};
        end
      end else if (update_dr && sel_ok) begin
        mod_id    <= id_sr;
        mod_valid <= 1'b1;
      end
    end
  end
endmodule

module dbg_modsel_rx_chk #(
  parameter int ID_W  = 4,
  parameter int CRC_W = 32,
  parameter int CW    = 7
) (
  input logic            tck,
  input logic            tap_reset,
  input logic            debug_sel,
  input logic            shift_dr,
  input logic            update_dr,
  input logic            tdo,
  input logic [ID_W-1:0] mod_id,
  input logic            mod_valid,
  input logic [CW-1:0]   bit_cnt
);
  localparam int ST0 = 1 + ID_W + CRC_W;

  p_sel_on_update_r5: assert property (@(posedge tck) disable iff (tap_reset)
    !$stable({mod_id, mod_valid}) |-> $past(update_dr) && $past(debug_sel));

  p_tdo_quiet_r8: assert property (@(posedge tck) disable iff (tap_reset)
    (!shift_dr || !debug_sel) |-> !tdo);

  p_stat_bit0_r3: assert property (@(posedge tck) disable iff (tap_reset)
    (shift_dr && bit_cnt == CW'(ST0 + 3)) |-> !tdo);

  p_valid_sticky_r7: assert property (@(posedge tck) disable iff (tap_reset)
    !$fell(mod_valid));

  p_reset_clear_r7: assert property (@(posedge tck)
    tap_reset |=> (tap_reset || (!mod_valid && mod_id == '0)) || $past(update_dr));
endmodule

bind dbg_modsel_rx dbg_modsel_rx_chk #(.ID_W(ID_W), .CRC_W(CRC_W), .CW(CW)) chk_i (.*);

// File: tb/dbg_modsel_rx_tb.sv
module dbg_modsel_rx_tb_top;
  localparam int ID_W = 4;
  localparam int NSH  = 1 + ID_W + 32 + 4 + 32;
  localparam int RXN  = 1 + ID_W + 32;

  logic tck = 1'b0, tap_reset = 1'b1, debug_sel = 1'b1;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic tdo, mod_valid;
  logic [ID_W-1:0] mod_id;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [ID_W-1:0] exp_id = '0;
  logic exp_v = 1'b0;

  always #10 tck = ~tck;

  dbg_modsel_rx dut_i (.tck(tck), .tap_reset(tap_reset), .debug_sel(debug_sel),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo), .mod_id(mod_id), .mod_valid(mod_valid));

  function automatic logic [31:0] step(input logic [31:0] c, input logic b);
    return {c[30:0], 1'b0} ^ ((c[31] ^ b) ? 32'h04C11DB7 : 32'h0);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_sel(input string req);
    chk(mod_id == exp_id && mod_valid == exp_v, req, {mod_valid, mod_id}, {exp_v, exp_id});
  endtask

  task automatic frame(input bit dsel, input bit mk, input logic [ID_W-1:0] id,
                       input bit bad, input int nsh, input string req);
    logic [31:0] c, oc;
    logic [3:0]  st;
    logic [35:0] got, expr;
    logic [RXN-1:0] tx;
    bit early = 0;
    c = '1;
    c = step(c, mk);
    for (int i = ID_W-1; i >= 0; i--) c = step(c, id[i]);
    tx = {mk, id, c ^ {31'b0, bad}};
    st = {bad, 1'b0, id >= 2, 1'b0};
    oc = '1;
    for (int i = 3; i >= 0; i--) oc = step(oc, st[i]);
    expr = (dsel && mk) ? {st, oc} : '0;
    got = '0;
    @(negedge tck);
    debug_sel = dsel; capture_dr = 1'b1;
    for (int k = 0; k < nsh; k++) begin
      @(negedge tck);
      capture_dr = 1'b0; shift_dr = 1'b1;
      tdi = (k < RXN) ? tx[RXN-1-k] : 1'b0;
      #1;
      if (k < RXN) begin if (tdo) early = 1; end
      else got[NSH-1-k] = tdo;
    end
    @(negedge tck);
    capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b1;
    #1 if (tdo) early = 1;
    @(negedge tck);
    update_dr = 1'b0;
    #1;
    if (nsh == NSH) begin
      chk(got == expr && !early, req, {27'b0, early, got}, {28'b0, expr});
    end
    if (dsel && mk && !bad && id < 2 && nsh >= RXN) begin
      exp_id = id; exp_v = 1'b1;
    end
    check_sel(req);
    debug_sel = 1'b1;
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd2024);
    repeat (3) @(negedge tck);
    tap_reset = 1'b0;
    #1 check_sel("R7 reset state");
    chk(tdo == 1'b0, "R8 tdo idle after reset", tdo, 0);

    frame(1, 1, 4'd1, 0, NSH, "R1 R2 R4 R5 select cpu");
    frame(1, 1, 4'd0, 0, NSH, "R5 R10 select bus");
    frame(1, 1, 4'd2, 0, NSH, "R3 bad id keeps selection");
    frame(1, 1, 4'd15, 1, NSH, "R2 R3 crc and id both bad");
    frame(1, 1, 4'd1, 1, NSH, "R2 R5 crc mismatch blocks select");
    frame(1, 0, 4'd1, 0, NSH, "R6 command frame ignored");
    frame(1, 1, 4'd1, 0, 20, "R9 truncated frame");
    frame(0, 1, 4'd1, 0, NSH, "R8 debug not selected");
    frame(1, 1, 4'd1, 0, NSH, "R10 back to back select");

    for (int n = 0; n < 60; n++) begin
      bit mk, bad;
      logic [ID_W-1:0] id;
      int len;
      mk  = ($urandom % 5) != 0;
      bad = ($urandom % 4) == 0;
      id  = ($urandom % 3 == 0) ? ID_W'($urandom) : ID_W'($urandom % 2);
      len = ($urandom % 6 == 0) ? int'($urandom % NSH) : NSH;
      frame(1, mk, id, bad, len, "R1 R5 R9 random frame");
    end

    @(negedge tck);
    tap_reset = 1'b1;
    @(negedge tck);
    tap_reset = 1'b0;
    exp_id = '0; exp_v = 1'b0;
    #1 check_sel("R7 reset clears selection");
    frame(1, 1, 4'd0, 0, NSH, "R5 select after reset");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule